// File: doc/BRIEF.md
# PLL Retune Sequencer

This block retunes a clock-generation PLL to a requested output frequency without software stepping through the sequence. A client puts a target rate in hertz on `target_hz_i` and pulses `start_i`. The block snaps the request to the nearest rate in a fixed table of 21 supported settings. It builds the PLL control word from the divider codes of that entry and writes it through a one-word-per-cycle register-write port. It then waits a fixed lock interval and judges the PLL status input.

A core-interface clock divider sits next to the PLL and must never see a core clock above 500 MHz at divide-by-1. The block therefore handles the two directions differently. A retune to a rate above 500 MHz first switches the interface divider to divide-by-2 and then writes the PLL. A retune to 500 MHz or below writes the PLL first, and only switches the divider back to divide-by-1 after the PLL has locked cleanly. The block also reports the output frequency implied by the last control word it wrote.

Top module: `pll_retune_seq`

## Requirements
- R1: The chosen table entry is the one whose rate has the smallest absolute distance to `target_hz_i`. When two entries are equally distant, the lower-rate entry wins. Targets below the table pick 100 MHz, and targets above it pick 1.6 GHz.
- R2: The control word is written with `wr_sel_o`=0. Its fields are: bit 0 power-down, bit 1 bypass (both written as 0), bits 3:2 output divider code, bits 8:4 input divider code, bits 15:9 feedback divider code and bits 23:20 band code. All other bits are 0.
- R3: When the chosen rate is above 500 MHz, the interface divider is written (`wr_sel_o`=1) with value 1 (divide-by-2). This write happens in the cycle directly before the control-word write.
- R4: The status input is judged in the cycle that lies LOCK_CYC+1 cycles after the control-word write cycle, where LOCK_CYC = SYS_CLK_HZ/1e6 × LOCK_US.
- R5: At that judgement, status bit 0 clear gives timeout, whatever bit 1 is. Bit 0 set with bit 1 (error) set gives error. Otherwise the result is success.
- R6: The interface divider is written with value 0 (divide-by-1) only after a success at a chosen rate of 500 MHz or below, one cycle after the judgement. No interface-divider write follows a timeout or an error.
- R7: `done_o` is a one-cycle pulse per run. `result_o` (0 none, 1 success, 2 timeout, 3 error) takes its new value in the cycle of that pulse and holds it until the next pulse.
- R8: A `start_i` seen while `busy_o` is high is ignored: the run in progress keeps its target, and exactly one control word is written per run.
- R9: The synchronous active-high reset `rst` returns the block to idle with no register write. After reset `busy_o`=0, `done_o`=0, `result_o`=0 and `est_hz_o`=0.
- R10: `est_hz_o` equals floor(REF_HZ × 2·(fb+1) / ((in+1)·2^out)) for the last control word written. It is 0 when the power-down bit of that word is set (as after reset) and REF_HZ when the bypass bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a retune |
| target_hz_i | input | 32 | Requested rate in Hz, sampled with the start strobe |
| pll_stat_i | input | 2 | PLL status: bit 0 lock, bit 1 error |
| wr_en_o | output | 1 | Register write strobe |
| wr_sel_o | output | 1 | Write target: 0 PLL control, 1 interface divider |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | High from the accepted start until the done cycle inclusive |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Outcome of the last run |
| est_hz_o | output | 32 | Frequency implied by the last control word |

## Verification
Two things can collide in one cycle. The first is a lock arriving in the very cycle the status is judged, against one arriving a cycle later. The bench's PLL model raises lock exactly LOCK_CYC+1 cycles after the control write in one mode and one cycle later in another, and expects success and timeout respectively. The second is a new start strobe landing while a retune is in its wait interval. The bench pulses start with a different target mid-run and judges by the single control word written, the unchanged interface-divider ordering and the run's unchanged result.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int unsigned NUM_RATES = 21;
  localparam int unsigned IDX_W     = $clog2(NUM_RATES);
  localparam int unsigned RATE_W    = 32;
  localparam int unsigned CTRL_W    = 32;

  localparam logic WSEL_PLL   = 1'b0;
  localparam logic WSEL_IFDIV = 1'b1;

  localparam logic [CTRL_W-1:0] IFDIV_BY1 = 32'd0;
  localparam logic [CTRL_W-1:0] IFDIV_BY2 = 32'd1;
  localparam logic [CTRL_W-1:0] CTRL_PD   = 32'd1;

  typedef struct packed {
    logic [4:0] in_code;
    logic [6:0] fb_code;
    logic [1:0] out_code;
    logic [3:0] band;
  } pll_fields_t;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_OK      = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_ERROR   = 2'd3
  } seq_result_t;

  // Supported rates in ascending order: the order encodes the tie rule.
  function automatic logic [RATE_W-1:0] entry_rate(input logic [IDX_W-1:0] idx);
    logic [RATE_W-1:0] r;
    case (idx)
      5'd0:    r = 32'd100_000_000;
      5'd1:    r = 32'd125_000_000;
      5'd2:    r = 32'd133_000_000;
      5'd3:    r = 32'd150_000_000;
      5'd4:    r = 32'd200_000_000;
      5'd5:    r = 32'd233_000_000;
      5'd6:    r = 32'd300_000_000;
      5'd7:    r = 32'd333_000_000;
      5'd8:    r = 32'd400_000_000;
      default: r = 32'd500_000_000 + RATE_W'(idx - 5'd9) * 32'd100_000_000;
    endcase
    return r;
  endfunction

  function automatic pll_fields_t entry_fields(input logic [IDX_W-1:0] idx);
    pll_fields_t f;
    f.band = 4'd0;
    case (idx)
      5'd0:    begin f.in_code = 5'd0; f.fb_code = 7'd11; f.out_code = 2'd3; end
      5'd1:    begin f.in_code = 5'd0; f.fb_code = 7'd14; f.out_code = 2'd3; end
      5'd2:    begin f.in_code = 5'd0; f.fb_code = 7'd15; f.out_code = 2'd3; end
      5'd3:    begin f.in_code = 5'd0; f.fb_code = 7'd17; f.out_code = 2'd3; end
      5'd4:    begin f.in_code = 5'd1; f.fb_code = 7'd47; f.out_code = 2'd3; end
      5'd5:    begin f.in_code = 5'd1; f.fb_code = 7'd27; f.out_code = 2'd2; end
      5'd6:    begin f.in_code = 5'd1; f.fb_code = 7'd35; f.out_code = 2'd2; end
      5'd7:    begin f.in_code = 5'd1; f.fb_code = 7'd39; f.out_code = 2'd2; end
      5'd8:    begin f.in_code = 5'd1; f.fb_code = 7'd47; f.out_code = 2'd2; end
      5'd9:    begin f.in_code = 5'd0; f.fb_code = 7'd14; f.out_code = 2'd1; end
      5'd10:   begin f.in_code = 5'd0; f.fb_code = 7'd17; f.out_code = 2'd1; end
      5'd11:   begin f.in_code = 5'd0; f.fb_code = 7'd20; f.out_code = 2'd1; end
      5'd12:   begin f.in_code = 5'd0; f.fb_code = 7'd23; f.out_code = 2'd1; end
      default: begin
        f.in_code  = 5'd1;
        f.fb_code  = 7'd26 + 7'(idx - 5'd13) * 7'd3;
        f.out_code = 2'd0;
      end
    endcase
    return f;
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(input pll_fields_t f);
    return {8'd0, f.band, 4'd0, f.fb_code, f.in_code, f.out_code, 2'b00};
  endfunction

  function automatic logic [RATE_W:0] abs_dist(input logic [RATE_W-1:0] a,
                                               input logic [RATE_W-1:0] b);
    return (a > b) ? {1'b0, a - b} : {1'b0, b - a};
  endfunction

  function automatic logic [63:0] pll_out_hz(input logic [CTRL_W-1:0] w,
                                             input logic [63:0] ref_hz);
    logic [63:0] num;
    logic [63:0] den;
    if (w[0]) return 64'd0;
    if (w[1]) return ref_hz;
    num = ref_hz * (64'(w[15:9]) + 64'd1) * 64'd2;
    den = (64'(w[8:4]) + 64'd1) << w[3:2];
    return num / den;
  endfunction

endpackage

// File: rtl/pllseq_rate_pick.sv
module pllseq_rate_pick
  import pllseq_pkg::*;
(
  input  logic [RATE_W-1:0] target_hz_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [RATE_W:0] best_d;
  logic [RATE_W:0] cand_d;

  // Strict compare keeps the earlier (lower) entry on equal distance.
  always_comb begin
    idx_o  = '0;
    best_d = abs_dist(target_hz_i, entry_rate('0));
    for (int i = 1; i < NUM_RATES; i++) begin
      cand_d = abs_dist(target_hz_i, entry_rate(IDX_W'(i)));
      if (cand_d < best_d) begin
        best_d = cand_d;
        idx_o  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pllseq_lock_timer.sv
module pllseq_lock_timer #(
  parameter int unsigned LOCK_CYC = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (LOCK_CYC < 2) ? 1 : $clog2(LOCK_CYC);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CNT_W'(LOCK_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (arm_i) cnt_q <= '0;
    else if (run_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (32'(cnt_q) < LOCK_CYC));
endmodule

// File: rtl/pllseq_rate_monitor.sv
module pllseq_rate_monitor
  import pllseq_pkg::*;
#(
  parameter longint unsigned REF_HZ = 33_333_333
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [RATE_W-1:0] est_hz_o
);
  logic [CTRL_W-1:0] shadow_q;
  logic [63:0]       est_full;

  always_ff @(posedge clk) begin
    if (rst) shadow_q <= CTRL_PD;
    else if (wr_en_i && wr_sel_i == WSEL_PLL) shadow_q <= wr_data_i;
  end

  assign est_full = pll_out_hz(shadow_q, 64'(REF_HZ));
  assign est_hz_o = RATE_W'(est_full);

  p_est_follows_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i == WSEL_PLL && wr_data_i[0]) |=> (est_hz_o == '0));
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pllseq_pkg::*;
#(
  parameter longint unsigned SYS_CLK_HZ = 200_000_000,
  parameter int unsigned     LOCK_US    = 100,
  parameter longint unsigned THRESH_HZ  = 500_000_000,
  parameter longint unsigned REF_HZ     = 33_333_333
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [RATE_W-1:0] target_hz_i,
  input  logic [1:0]        pll_stat_i,
  output logic              wr_en_o,
  output logic              wr_sel_o,
  output logic [CTRL_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [RATE_W-1:0] est_hz_o
);
  localparam int unsigned LOCK_CYC_RAW = int'(SYS_CLK_HZ / 64'd1_000_000) * LOCK_US;
  localparam int unsigned LOCK_CYC     = (LOCK_CYC_RAW < 1) ? 1 : LOCK_CYC_RAW;
  localparam int unsigned GAP_W        = $clog2(LOCK_CYC + 2) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_CTRL, ST_WAIT, ST_CHECK, ST_POST, ST_DONE
  } seq_state_t;

  seq_state_t       st_q;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] sel_idx_q;
  logic             pick_hi;
  logic             hi_q;
  seq_result_t      result_q;
  seq_result_t      res_pend_q;
  seq_result_t      chk_code;

  // Named internal events
  logic pre_div_wr;
  logic ctrl_wr;
  logic post_div_wr;
  logic wait_run;
  logic wait_expire;
  logic chk_now;
  logic chk_ok;

  pllseq_rate_pick u_pick (
    .target_hz_i (target_hz_i),
    .idx_o       (pick_idx)
  );

  assign pick_hi = (64'(entry_rate(pick_idx)) > THRESH_HZ);

  pllseq_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (ctrl_wr),
    .run_i    (wait_run),
    .expire_o (wait_expire)
  );

  assign pre_div_wr  = (st_q == ST_PRE);
  assign ctrl_wr     = (st_q == ST_CTRL);
  assign post_div_wr = (st_q == ST_POST);
  assign wait_run    = (st_q == ST_WAIT);
  assign chk_now     = (st_q == ST_CHECK);

  // Missing lock outranks the error flag.
  always_comb begin
    if (!pll_stat_i[0])     chk_code = RES_TIMEOUT;
    else if (pll_stat_i[1]) chk_code = RES_ERROR;
    else                    chk_code = RES_OK;
  end
  assign chk_ok = chk_now && (chk_code == RES_OK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      sel_idx_q  <= '0;
      hi_q       <= 1'b0;
      result_q   <= RES_NONE;
      res_pend_q <= RES_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          sel_idx_q <= pick_idx;
          hi_q      <= pick_hi;
          st_q      <= pick_hi ? ST_PRE : ST_CTRL;
        end
        ST_PRE:  st_q <= ST_CTRL;
        ST_CTRL: st_q <= ST_WAIT;
        ST_WAIT: if (wait_expire) st_q <= ST_CHECK;
        ST_CHECK: begin
          res_pend_q <= chk_code;
          if (chk_ok && !hi_q) begin
            st_q <= ST_POST;
          end else begin
            result_q <= chk_code;
            st_q     <= ST_DONE;
          end
        end
        ST_POST: begin
          result_q <= res_pend_q;
          st_q     <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o   = pre_div_wr || ctrl_wr || post_div_wr;
    wr_sel_o  = ctrl_wr ? WSEL_PLL : WSEL_IFDIV;
    wr_data_o = '0;
    if (ctrl_wr)         wr_data_o = pack_ctrl(entry_fields(sel_idx_q));
    else if (pre_div_wr) wr_data_o = IFDIV_BY2;
    else if (post_div_wr) wr_data_o = IFDIV_BY1;
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_DONE);
  assign result_o = result_q;

  pllseq_rate_monitor #(.REF_HZ(REF_HZ)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_o),
    .wr_sel_i  (wr_sel_o),
    .wr_data_i (wr_data_o),
    .est_hz_o  (est_hz_o)
  );

  // Cycles from control write to judgement, counted independently of the timer.
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)                gap_q <= '0;
    else if (ctrl_wr)       gap_q <= '0;
    else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
  end

  always @(posedge clk) begin
    if (!rst && chk_now) begin
      p_lock_wait_r4: assert (gap_q == GAP_W'(LOCK_CYC))
        else $error("lock wait length %0d", gap_q);
    end
  end

  p_ctrl_clean_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |-> (wr_data_o[1:0] == 2'b00 && wr_sel_o == WSEL_PLL));

  p_div2_first_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && hi_q) |-> $past(pre_div_wr));

  p_timeout_prio_r5: assert property (@(posedge clk) disable iff (rst)
    (chk_now && !pll_stat_i[0]) |=> (done_o && result_o == RES_TIMEOUT));

  p_div1_after_ok_r6: assert property (@(posedge clk) disable iff (rst)
    post_div_wr |-> ($past(chk_ok) && !hi_q));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> done_o);

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(sel_idx_q));

  p_one_write_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pre_div_wr, ctrl_wr, post_div_wr}));
endmodule

// File: tb/pll_retune_seq_test.sv
module pll_retune_seq_test;
  localparam int  L    = 20;
  localparam longint REF = 33_333_333;
  localparam longint THR = 500_000_000;
  localparam int  N    = 21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] target_hz_i = '0;
  logic [1:0]  pll_stat_i = '0;
  logic        wr_en_o, wr_sel_o, busy_o, done_o;
  logic [31:0] wr_data_o, est_hz_o;
  logic [1:0]  result_o;

  pll_retune_seq #(.SYS_CLK_HZ(1_000_000), .LOCK_US(L)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .target_hz_i(target_hz_i),
    .pll_stat_i(pll_stat_i), .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o),
    .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .est_hz_o(est_hz_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  longint tb_rate[N] = '{100_000_000, 125_000_000, 133_000_000, 150_000_000,
    200_000_000, 233_000_000, 300_000_000, 333_000_000, 400_000_000,
    500_000_000, 600_000_000, 700_000_000, 800_000_000, 900_000_000,
    1_000_000_000, 1_100_000_000, 1_200_000_000, 1_300_000_000,
    1_400_000_000, 1_500_000_000, 1_600_000_000};
  int tb_in[N]  = '{0,0,0,0,1,1,1,1,1,0,0,0,0,1,1,1,1,1,1,1,1};
  int tb_fb[N]  = '{11,14,15,17,47,27,35,39,47,14,17,20,23,26,29,32,35,38,41,44,47};
  int tb_out[N] = '{3,3,3,3,3,2,2,2,2,1,1,1,1,0,0,0,0,0,0,0,0};

  // Per-run log and PLL model
  int     n_ctrl, n_pre, n_post, n_done, n_wr_total;
  longint ctrl_cyc, pre_cyc, done_cyc;
  logic [31:0] ctrl_val, pre_val, post_val;
  logic [1:0]  done_res;
  int  lock_delay = L + 1;
  bit  m_lock = 1'b1, m_err = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (wr_en_o) begin
      n_wr_total++;
      if (wr_sel_o == 1'b0) begin
        n_ctrl++; ctrl_val = wr_data_o; ctrl_cyc = cyc;
      end else if (n_ctrl == 0) begin
        n_pre++; pre_val = wr_data_o; pre_cyc = cyc;
      end else begin
        n_post++; post_val = wr_data_o;
      end
    end
    if (done_o) begin
      n_done++; done_cyc = cyc; done_res = result_o;
    end
    if (n_ctrl > 0 && (cyc - ctrl_cyc) >= lock_delay) pll_stat_i = {m_err, m_lock};
    else pll_stat_i = 2'b00;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nearest(input longint t);
    int best = N - 1;
    longint bd = (t > tb_rate[N-1]) ? t - tb_rate[N-1] : tb_rate[N-1] - t;
    for (int i = N - 1; i >= 0; i--) begin
      longint d = (t > tb_rate[i]) ? t - tb_rate[i] : tb_rate[i] - t;
      if (d <= bd) begin bd = d; best = i; end
    end
    return best;
  endfunction

  function automatic longint exp_hz(input int k);
    longint v = REF * 2 * (tb_fb[k] + 1);
    v = v >> tb_out[k];
    return v / (tb_in[k] + 1);
  endfunction

  // mode 0 ok, 1 late lock, 2 lock with error, 3 error without lock
  task automatic run_case(input longint tgt, input int mode, input bit poke);
    int k = nearest(tgt);
    bit hi = tb_rate[k] > THR;
    logic [1:0] er;
    longint ew;
    @(negedge clk);
    n_ctrl = 0; n_pre = 0; n_post = 0; n_done = 0;
    lock_delay = (mode == 1) ? L + 2 : L + 1;
    m_lock = (mode != 3);
    m_err  = (mode >= 2);
    target_hz_i = tgt[31:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      target_hz_i = hi ? 32'd100_000_000 : 32'd1_600_000_000;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int w = 0; w < 200 && n_done == 0; w++) @(negedge clk);
    @(negedge clk);
    er = (mode == 0) ? 2'd1 : (mode == 2) ? 2'd3 : 2'd2;
    ew = (longint'(tb_out[k]) << 2) | (longint'(tb_in[k]) << 4) | (longint'(tb_fb[k]) << 9);
    check(n_ctrl == 1, "R8 one control write per run", n_ctrl, 1);
    check(ctrl_val == ew[31:0], "R1/R2 control word for nearest entry", ctrl_val, ew);
    check(n_pre == (hi ? 1 : 0), "R3 pre-retune divide-by-2 write count", n_pre, hi ? 1 : 0);
    if (hi) begin
      check(pre_val == 32'd1, "R3 divide-by-2 value", pre_val, 1);
      check(pre_cyc == ctrl_cyc - 1, "R3 divider write right before control", pre_cyc, ctrl_cyc - 1);
    end
    check(n_post == ((mode == 0 && !hi) ? 1 : 0), "R6 post-lock divide-by-1 write count",
          n_post, (mode == 0 && !hi) ? 1 : 0);
    if (n_post == 1) check(post_val == 32'd0, "R6 divide-by-1 value", post_val, 0);
    check(n_done == 1, "R7 single done pulse", n_done, 1);
    check(done_res == er, "R5 result code", done_res, er);
    check(result_o == er, "R7 result held after done", result_o, er);
    check(done_cyc == ctrl_cyc + L + ((n_post == 1) ? 3 : 2), "R4 lock wait timing",
          done_cyc, ctrl_cyc + L + ((n_post == 1) ? 3 : 2));
    check(longint'(est_hz_o) == exp_hz(k), "R10 estimated rate", est_hz_o, exp_hz(k));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!wr_en_o && !busy_o && !done_o, "R9 idle after reset", {wr_en_o, busy_o, done_o}, 0);
    check(result_o == 2'd0, "R9 result after reset", result_o, 0);
    check(est_hz_o == 32'd0, "R9/R10 power-down estimate after reset", est_hz_o, 0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < N; i++) run_case(tb_rate[i], 0, 1'b0);
    for (int i = 0; i < N - 1; i++) begin
      longint s = tb_rate[i] + tb_rate[i+1];
      run_case(s / 2, 0, 1'b0);
      run_case(s / 2 + 1, 0, 1'b0);
    end
    run_case(0, 0, 1'b0);
    run_case(64'hFFFF_FFFF, 0, 1'b0);
    run_case(500_000_001, 0, 1'b0);

    for (int m = 1; m < 4; m++) begin
      run_case(300_000_000, m, 1'b0);
      run_case(1_200_000_000, m, 1'b0);
      run_case(500_000_000, m, 1'b0);
    end

    run_case(400_000_000, 0, 1'b1);
    run_case(900_000_000, 0, 1'b1);
    run_case(700_000_000, 2, 1'b1);

    // Reset in the middle of a wait
    @(negedge clk);
    n_ctrl = 0; lock_delay = L + 1; m_lock = 1'b1; m_err = 1'b0;
    target_hz_i = 32'd800_000_000; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    n_wr_total = 0;
    @(negedge clk);
    rst = 1'b0;
    repeat (L + 10) @(negedge clk);
    check(n_wr_total == 0, "R9 no write after mid-run reset", n_wr_total, 0);
    check(!busy_o && result_o == 2'd0, "R9 idle and cleared result", {busy_o, result_o}, 0);
    check(est_hz_o == 32'd0, "R9 estimate cleared", est_hz_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule